// File: doc/BRIEF.md
# Pipeline exception commit controller

This block is the exception and interrupt control unit for an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). Each stage can report one kind of fault for the instruction it holds. The block tracks a valid bit, a PC and a single fault code per in-flight instruction. It carries that record down the pipe and acts on it only when the instruction reaches the memory stage, which is the commit point.

At commit, any sampled external interrupt request outranks every synchronous fault. The unit then records the PC of the instruction in the exception PC register and the reason in the cause register. It clears the interrupt enable and enters kernel mode. It kills the three younger stages, blocks the committing instruction's writeback and steers fetch to a fixed handler address.

A return-from-exception that reaches commit does the reverse. It re-enables interrupts, drops to user mode and sends fetch to the saved exception PC. A small software port reads the exception PC or the cause register and writes the exception PC.

Top module: `exc_commit_ctrl`

## Requirements
- R1: Fault sources and codes. The cause code is 4 bits: 0 none, 1 interrupt, 2 fetch PC address fault, 3 decode illegal opcode, 4 execute overflow, 5 memory data address fault. Software sees it in bits 3:0 of the cause word.
- R2: A fault reported in fetch, decode or execute has no visible effect (no redirect, no kill) before its instruction reaches the memory stage.
- R3: When one instruction reports faults in several stages, the cause written is the one from the earliest stage.
- R4: Interrupt lines are registered once and then considered at commit. They are taken only if interrupt enable is 1 and a valid instruction is in the memory stage. An interrupt wins over any synchronous fault of that instruction.
- R5: A taken exception or interrupt raises redirect, the fetch, decode and execute kills, and the writeback kill in the commit cycle, with redirect PC equal to the HANDLER_PC parameter.
- R6: Handling is precise. An older, fault-free instruction commits (commit_o is 1), and the exception PC becomes the PC of the faulting or interrupted instruction from the next cycle on.
- R7: Taking an exception or interrupt clears interrupt enable and sets kernel mode. A request still held afterwards does not interrupt the next instruction.
- R8: A return-from-exception at commit raises redirect and the three front kills but not the writeback kill. The redirect PC is the exception PC. On the next cycle interrupt enable is 1 and kernel mode is 0.
- R9: Among active interrupt lines, the lowest index wins. Its index is stored in cause word bits 8 and up; a synchronous fault stores index 0.
- R10: A killed instruction is marked invalid. Its fault flags are ignored and it never commits or redirects.
- R11: The software port returns the exception PC when select is 0 and the cause word when select is 1. A write to the exception PC is visible from the next cycle. A taken exception in the same cycle overrides the write.
- R12: After reset: interrupt enable 0, kernel mode 1, exception PC 0, cause word 0, no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid_i | input | 1 | A valid instruction is in fetch |
| f_pc_i | input | AW | PC of the fetch instruction |
| f_fault_i | input | 1 | Fetch PC address fault |
| d_illegal_i | input | 1 | Illegal opcode for the decode instruction |
| e_ovf_i | input | 1 | Overflow for the execute instruction |
| m_dfault_i | input | 1 | Data address fault for the memory-stage instruction |
| m_eret_i | input | 1 | Memory-stage instruction is a return-from-exception |
| irq_i | input | NIRQ | External interrupt request lines, index 0 highest priority |
| sw_we_i | input | 1 | Software write of the exception PC |
| sw_sel_i | input | 1 | Read select: 0 exception PC, 1 cause word |
| sw_wdata_i | input | AW | Software write data |
| sw_rdata_o | output | AW | Software read data |
| commit_o | output | 1 | Memory-stage instruction commits this cycle |
| kill_f_o | output | 1 | Kill fetch stage |
| kill_d_o | output | 1 | Kill decode stage |
| kill_e_o | output | 1 | Kill execute stage |
| kill_wb_o | output | 1 | Suppress writeback of the memory-stage instruction |
| redirect_o | output | 1 | Fetch redirect |
| redirect_pc_o | output | AW | Redirect target |
| ie_o | output | 1 | Interrupt enable |
| kmode_o | output | 1 | Kernel mode |

## Verification
Take an instruction presented in fetch in cycle n. Its commit-point results (redirect, kills, commit, redirect PC) are due in cycle n+3, in the same cycle as its memory-stage flags. The cause word, exception PC and mode bits change at the edge that ends cycle n+3 and are read in n+4. An interrupt line must be high in cycle n+2 to be seen at n+3. A software write shows on the read port one cycle later. The bench drives each fault flag in the cycle its stage holds the instruction. It samples every output on the falling edge of the cycle where the result is due, and checks that no redirect appears in the cycles before.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE     = 4'd0,
    EXC_IRQ      = 4'd1,
    EXC_PCADDR   = 4'd2,
    EXC_ILLEGAL  = 4'd3,
    EXC_OVERFLOW = 4'd4,
    EXC_DADDR    = 4'd5
  } exc_code_e;

  // fault source index 0 = fetch, 1 = decode, 2 = execute, 3 = memory
  function automatic exc_code_e src_code(input int idx);
    return exc_code_e'(4'(idx + 2));
  endfunction

endpackage

// File: rtl/exc_stage_track.sv
`timescale 1ns/1ps
module exc_stage_track
  import exc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NSTG = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          f_valid_i,
  input  logic [AW-1:0] f_pc_i,
  input  logic [NSTG:0] fault_i,
  input  logic          flush_i,
  output logic          m_valid_o,
  output logic [AW-1:0] m_pc_o,
  output exc_code_e     m_code_o
);

  logic          vld_q  [NSTG];
  logic [AW-1:0] pc_q   [NSTG];
  exc_code_e     code_q [NSTG];
  logic          nxt_v  [NSTG];
  logic [AW-1:0] nxt_pc [NSTG];
  exc_code_e     nxt_c  [NSTG];
  logic [NSTG-1:0] vld_vec;

  // entry 0 holds the decode instruction, entry NSTG-1 the commit instruction
  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign nxt_v[k]  = f_valid_i;
      assign nxt_pc[k] = f_pc_i;
      assign nxt_c[k]  = fault_i[0] ? src_code(0) : EXC_NONE;
    end else begin : g_body
      assign nxt_v[k]  = vld_q[k-1];
      assign nxt_pc[k] = pc_q[k-1];
      // an earlier recorded fault is kept; otherwise the local one is added
      assign nxt_c[k]  = (code_q[k-1] != EXC_NONE) ? code_q[k-1]
                       : (fault_i[k] ? src_code(k) : EXC_NONE);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NSTG; k++) begin
      if (rst || flush_i) vld_q[k] <= 1'b0;
      else                vld_q[k] <= nxt_v[k];
      if (rst) begin
        pc_q[k]   <= '0;
        code_q[k] <= EXC_NONE;
      end else begin
        pc_q[k]   <= nxt_pc[k];
        code_q[k] <= nxt_c[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NSTG; k++) vld_vec[k] = vld_q[k];
  end

  assign m_valid_o = vld_q[NSTG-1];
  assign m_pc_o    = pc_q[NSTG-1];
  assign m_code_o  = (code_q[NSTG-1] != EXC_NONE) ? code_q[NSTG-1]
                   : (fault_i[NSTG] ? src_code(NSTG) : EXC_NONE);

  AST_FLUSH_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (vld_vec == '0)); // R10

endmodule

// File: rtl/exc_irq_prio.sv
`timescale 1ns/1ps
module exc_irq_prio #(
  parameter int NIRQ = 4,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            en_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);

  logic [NIRQ-1:0] req_q;
  logic [NIRQ-1:0] req_m;
  logic [NIRQ-1:0] low_mask;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= irq_i;
  end

  assign req_m = en_i ? req_q : '0;
  assign any_o = |req_m;

  always_comb begin
    idx_o = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (req_m[i]) idx_o = IDXW'(i);
    end
  end

  assign low_mask = (NIRQ'(1) << idx_o) - NIRQ'(1);

  AST_LOWEST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
    any_o |-> (req_m[idx_o] && ((req_m & low_mask) == '0))); // R9
  AST_MASKED_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> !any_o); // R4

endmodule

// File: rtl/exc_csr.sv
`timescale 1ns/1ps
module exc_csr
  import exc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  exc_code_e       take_code_i,
  input  logic [IDXW-1:0] take_idx_i,
  input  logic [AW-1:0]   take_pc_i,
  input  logic            eret_i,
  input  logic            sw_we_i,
  input  logic            sw_sel_i,
  input  logic [AW-1:0]   sw_wdata_i,
  output logic [AW-1:0]   epc_o,
  output logic            ie_o,
  output logic            kmode_o,
  output logic [AW-1:0]   rdata_o
);

  localparam int IDX_LSB = 8;

  logic [AW-1:0]   epc_q;
  exc_code_e       code_q;
  logic [IDXW-1:0] idx_q;
  logic            ie_q;
  logic            km_q;
  logic [AW-1:0]   cause_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q  <= '0;
      code_q <= EXC_NONE;
      idx_q  <= '0;
      ie_q   <= 1'b0;
      km_q   <= 1'b1;
    end else if (take_i) begin
      epc_q  <= take_pc_i;
      code_q <= take_code_i;
      idx_q  <= take_idx_i;
      ie_q   <= 1'b0;
      km_q   <= 1'b1;
    end else begin
      if (eret_i) begin
        ie_q <= 1'b1;
        km_q <= 1'b0;
      end
      if (sw_we_i) epc_q <= sw_wdata_i;
    end
  end

  always_comb begin
    cause_word                     = '0;
    cause_word[CODE_W-1:0]         = code_q;
    cause_word[IDX_LSB +: IDXW]    = idx_q;
  end

  assign rdata_o = sw_sel_i ? cause_word : epc_q;
  assign epc_o   = epc_q;
  assign ie_o    = ie_q;
  assign kmode_o = km_q;

  AST_TAKE_MASKS_IRQ: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (!ie_q && km_q)); // R7
  AST_ERET_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (eret_i && !take_i) |=> (ie_q && !km_q)); // R8
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (epc_q == $past(take_pc_i))); // R6
  AST_SW_EPC_WRITE: assert property (@(posedge clk) disable iff (rst)
    (sw_we_i && !take_i) |=> (epc_q == $past(sw_wdata_i))); // R11

endmodule

// File: rtl/exc_commit_ctrl.sv
`timescale 1ns/1ps
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          NIRQ       = 4,
  parameter logic [31:0] HANDLER_PC = 32'h0000_1010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            f_valid_i,
  input  logic [AW-1:0]   f_pc_i,
  input  logic            f_fault_i,
  input  logic            d_illegal_i,
  input  logic            e_ovf_i,
  input  logic            m_dfault_i,
  input  logic            m_eret_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            sw_we_i,
  input  logic            sw_sel_i,
  input  logic [AW-1:0]   sw_wdata_i,
  output logic [AW-1:0]   sw_rdata_o,
  output logic            commit_o,
  output logic            kill_f_o,
  output logic            kill_d_o,
  output logic            kill_e_o,
  output logic            kill_wb_o,
  output logic            redirect_o,
  output logic [AW-1:0]   redirect_pc_o,
  output logic            ie_o,
  output logic            kmode_o
);

  localparam int NSTG = 3;
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic            m_valid;
  logic [AW-1:0]   m_pc;
  exc_code_e       m_code;
  logic            irq_any;
  logic [IDXW-1:0] irq_idx;
  logic            irq_take;
  logic            exc_take;
  logic            take;
  logic            eret_c;
  logic            flush;
  exc_code_e       take_code;
  logic [IDXW-1:0] take_idx;
  logic [AW-1:0]   epc;
  logic            ie;
  logic [NSTG:0]   faults;

  assign faults = {m_dfault_i, e_ovf_i, d_illegal_i, f_fault_i};

  exc_stage_track #(.AW(AW), .NSTG(NSTG)) u_track (
    .clk       (clk),
    .rst       (rst),
    .f_valid_i (f_valid_i),
    .f_pc_i    (f_pc_i),
    .fault_i   (faults),
    .flush_i   (flush),
    .m_valid_o (m_valid),
    .m_pc_o    (m_pc),
    .m_code_o  (m_code)
  );

  exc_irq_prio #(.NIRQ(NIRQ), .IDXW(IDXW)) u_prio (
    .clk   (clk),
    .rst   (rst),
    .irq_i (irq_i),
    .en_i  (ie),
    .any_o (irq_any),
    .idx_o (irq_idx)
  );

  // commit-point decision: interrupt, then synchronous fault, then return
  assign irq_take  = m_valid && irq_any;
  assign exc_take  = m_valid && (m_code != EXC_NONE);
  assign take      = irq_take || exc_take;
  assign eret_c    = m_valid && m_eret_i && !take;
  assign flush     = take || eret_c;
  assign take_code = irq_take ? EXC_IRQ : m_code;
  assign take_idx  = irq_take ? irq_idx : '0;

  exc_csr #(.AW(AW), .IDXW(IDXW)) u_csr (
    .clk         (clk),
    .rst         (rst),
    .take_i      (take),
    .take_code_i (take_code),
    .take_idx_i  (take_idx),
    .take_pc_i   (m_pc),
    .eret_i      (eret_c),
    .sw_we_i     (sw_we_i),
    .sw_sel_i    (sw_sel_i),
    .sw_wdata_i  (sw_wdata_i),
    .epc_o       (epc),
    .ie_o        (ie),
    .kmode_o     (kmode_o),
    .rdata_o     (sw_rdata_o)
  );

  assign commit_o      = m_valid && !take;
  assign kill_f_o      = flush;
  assign kill_d_o      = flush;
  assign kill_e_o      = flush;
  assign kill_wb_o     = take;
  assign redirect_o    = flush;
  assign redirect_pc_o = take ? AW'(HANDLER_PC) : epc;
  assign ie_o          = ie;

  AST_REDIRECT_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> m_valid); // R2
  AST_WB_KILL_NOT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !(kill_wb_o && commit_o)); // R5

endmodule

// File: tb/exc_commit_ctrl_test.sv
`timescale 1ns/1ps
module exc_commit_ctrl_test;

  localparam logic [31:0] HANDLER = 32'h0000_1010;

  typedef struct packed {
    logic       pcf;
    logic       ill;
    logic       ovf;
    logic       df;
    logic       er;
    logic [3:0] irq;
    logic [1:0] kind;  // 0 commit, 1 take, 2 return
    logic [3:0] code;
    logic [1:0] idx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,2'd2,4'd0,2'd0}, // return, enables
    '{1'b0,1'b0,1'b1,1'b0,1'b0,4'b0110,2'd1,4'd1,2'd1}, // irq beats overflow
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,2'd2,4'd0,2'd0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'b0000,2'd1,4'd2,2'd0}, // fetch fault earliest
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'b0001,2'd1,4'd3,2'd0}, // irq masked
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,2'd2,4'd0,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,2'd0,4'd0,2'd0}, // plain commit
    '{1'b0,1'b0,1'b1,1'b1,1'b0,4'b0000,2'd1,4'd4,2'd0}, // overflow earliest
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,2'd2,4'd0,2'd0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'b0000,2'd1,4'd5,2'd0}, // data fault
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,2'd2,4'd0,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b1000,2'd1,4'd1,2'd3}, // irq beats return
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,2'd2,4'd0,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,2'd1,4'd1,2'd0}  // line 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        f_valid_i = 1'b0;
  logic [31:0] f_pc_i = '0;
  logic        f_fault_i = 1'b0;
  logic        d_illegal_i = 1'b0;
  logic        e_ovf_i = 1'b0;
  logic        m_dfault_i = 1'b0;
  logic        m_eret_i = 1'b0;
  logic [3:0]  irq_i = '0;
  logic        sw_we_i = 1'b0;
  logic        sw_sel_i = 1'b0;
  logic [31:0] sw_wdata_i = '0;
  logic [31:0] sw_rdata_o;
  logic        commit_o, kill_f_o, kill_d_o, kill_e_o, kill_wb_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic        ie_o, kmode_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] m_epc   = '0;
  logic [31:0] m_cause = '0;
  logic        m_ie    = 1'b0;
  logic        m_km    = 1'b1;

  always #2 clk = ~clk;

  exc_commit_ctrl #(.AW(32), .NIRQ(4), .HANDLER_PC(HANDLER)) uut (
    .clk(clk), .rst(rst), .f_valid_i(f_valid_i), .f_pc_i(f_pc_i),
    .f_fault_i(f_fault_i), .d_illegal_i(d_illegal_i), .e_ovf_i(e_ovf_i),
    .m_dfault_i(m_dfault_i), .m_eret_i(m_eret_i), .irq_i(irq_i),
    .sw_we_i(sw_we_i), .sw_sel_i(sw_sel_i), .sw_wdata_i(sw_wdata_i),
    .sw_rdata_o(sw_rdata_o), .commit_o(commit_o), .kill_f_o(kill_f_o),
    .kill_d_o(kill_d_o), .kill_e_o(kill_e_o), .kill_wb_o(kill_wb_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .ie_o(ie_o), .kmode_o(kmode_o)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    f_valid_i = 1'b0; f_fault_i = 1'b0; d_illegal_i = 1'b0; e_ovf_i = 1'b0;
    m_dfault_i = 1'b0; m_eret_i = 1'b0; sw_we_i = 1'b0; sw_sel_i = 1'b0;
  endtask

  task automatic check_state(input string req);
    sw_sel_i = 1'b1;
    #0.5;
    chk(sw_rdata_o == m_cause, req, "cause word", sw_rdata_o, m_cause);
    chk(ie_o == m_ie, req, "interrupt enable", 32'(ie_o), 32'(m_ie));
    chk(kmode_o == m_km, req, "kernel mode", 32'(kmode_o), 32'(m_km));
    sw_sel_i = 1'b0;
    #0.5;
    chk(sw_rdata_o == m_epc, req, "exception PC", sw_rdata_o, m_epc);
  endtask

  // one instruction through F, D, E, M with flags in the right cycles
  task automatic run_vec(input int n, input vec_t v);
    logic [31:0] pc;
    logic [5:0]  outs;
    string       tg;
    pc = 32'h1000 + 32'(n) * 32'd16;
    idle(); irq_i = '0; f_valid_i = 1'b1; f_pc_i = pc; f_fault_i = v.pcf;
    @(negedge clk);
    chk(redirect_o == 1'b0, "R2", "redirect in fetch cycle", 32'(redirect_o), 0);
    nxt();
    idle(); d_illegal_i = v.ill;
    @(negedge clk);
    chk(redirect_o == 1'b0, "R2", "redirect in decode cycle", 32'(redirect_o), 0);
    nxt();
    idle(); e_ovf_i = v.ovf; irq_i = v.irq;
    @(negedge clk);
    chk(redirect_o == 1'b0, "R2", "redirect in execute cycle", 32'(redirect_o), 0);
    nxt();
    idle(); irq_i = '0; m_dfault_i = v.df; m_eret_i = v.er;
    @(negedge clk);
    outs = {redirect_o, kill_wb_o, commit_o, kill_f_o, kill_d_o, kill_e_o};
    case (v.kind)
      2'd0: chk(outs == 6'b001000, "R6", "commit outputs", 32'(outs), 32'h08);
      2'd1: begin
        chk(outs == 6'b110111, "R5", "take outputs", 32'(outs), 32'h37);
        chk(redirect_pc_o == HANDLER, "R5", "handler PC", redirect_pc_o, HANDLER);
      end
      default: begin
        chk(outs == 6'b101111, "R8", "return outputs", 32'(outs), 32'h2f);
        chk(redirect_pc_o == m_epc, "R8", "return PC", redirect_pc_o, m_epc);
      end
    endcase
    nxt();
    idle();
    if (v.kind == 2'd1) begin
      m_epc = pc; m_ie = 1'b0; m_km = 1'b1;
      m_cause = 32'(v.code) | (32'(v.idx) << 8);
      if (v.code == 4'd1) tg = (v.idx != 0) ? "R9" : "R4";
      else if ($countones({v.pcf, v.ill, v.ovf, v.df}) > 1) tg = "R3";
      else tg = "R1";
      check_state(tg);
    end else if (v.kind == 2'd2) begin
      m_ie = 1'b1; m_km = 1'b0;
      check_state("R8");
    end else begin
      check_state("R6");
    end
    nxt();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle();
    @(negedge clk);
    chk(redirect_o == 1'b0, "R12", "redirect after reset", 32'(redirect_o), 0);
    check_state("R12");
    nxt();

    // software write of the exception PC: old value now, new value next cycle
    idle(); sw_we_i = 1'b1; sw_wdata_i = 32'h0000_0200;
    @(negedge clk);
    chk(sw_rdata_o == 32'h0, "R11", "read before write lands", sw_rdata_o, 0);
    nxt();
    idle();
    @(negedge clk);
    chk(sw_rdata_o == 32'h200, "R11", "read after write", sw_rdata_o, 32'h200);
    m_epc = 32'h200;
    nxt();

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // killed instructions behind a taken fault (R10)
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h3000;
    nxt();
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h3004; f_fault_i = 1'b1; d_illegal_i = 1'b1;
    nxt();
    idle(); d_illegal_i = 1'b1;
    nxt();
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h3008; e_ovf_i = 1'b1;
    @(negedge clk);
    chk(redirect_o == 1'b1, "R10", "first fault taken", 32'(redirect_o), 1);
    nxt();
    idle();
    @(negedge clk);
    chk({redirect_o, commit_o} == 2'b00, "R10", "killed instr in M", 32'({redirect_o, commit_o}), 0);
    m_epc = 32'h3000; m_cause = 32'd3; m_ie = 1'b0; m_km = 1'b1;
    check_state("R10");
    nxt();
    idle();
    @(negedge clk);
    chk({redirect_o, commit_o} == 2'b00, "R10", "killed fetch instr", 32'({redirect_o, commit_o}), 0);
    nxt();

    // precise: older instruction commits, younger faults next cycle (R6)
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h4000;
    nxt();
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h4004;
    nxt();
    idle();
    nxt();
    idle(); e_ovf_i = 1'b1;
    @(negedge clk);
    chk({redirect_o, commit_o} == 2'b01, "R6", "older instr commits", 32'({redirect_o, commit_o}), 1);
    nxt();
    idle();
    @(negedge clk);
    chk({redirect_o, kill_wb_o} == 2'b11, "R6", "younger fault taken", 32'({redirect_o, kill_wb_o}), 3);
    nxt();
    idle();
    m_epc = 32'h4004; m_cause = 32'd4;
    check_state("R6");
    nxt();

    // return, then interrupt waits for a valid instruction (R4)
    run_vec(20, '{1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,2'd2,4'd0,2'd0});
    irq_i = 4'b0010;
    for (int c = 0; c < 3; c++) begin
      idle();
      @(negedge clk);
      chk(redirect_o == 1'b0, "R4", "no take without instruction", 32'(redirect_o), 0);
      nxt();
    end
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h5000;
    nxt();
    idle();
    nxt();
    idle();
    nxt();
    idle();
    @(negedge clk);
    chk({redirect_o, kill_wb_o} == 2'b11, "R4", "interrupt taken", 32'({redirect_o, kill_wb_o}), 3);
    nxt();
    idle();
    m_epc = 32'h5000; m_cause = 32'h101; m_ie = 1'b0; m_km = 1'b1;
    check_state("R9");
    nxt();
    // request still held, interrupts now disabled (R7)
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h5010;
    nxt();
    idle();
    nxt();
    idle();
    nxt();
    idle();
    @(negedge clk);
    chk({redirect_o, commit_o} == 2'b01, "R7", "held irq blocked", 32'({redirect_o, commit_o}), 1);
    nxt();
    irq_i = '0;

    // hardware take beats a same-cycle software write (R11)
    idle(); f_valid_i = 1'b1; f_pc_i = 32'h6000;
    nxt();
    idle(); d_illegal_i = 1'b1;
    nxt();
    idle();
    nxt();
    idle(); sw_we_i = 1'b1; sw_wdata_i = 32'h0000_0abc;
    nxt();
    idle();
    m_epc = 32'h6000; m_cause = 32'd3;
    check_state("R11");
    nxt();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule